// File: doc/BRIEF.md
# Power domain switch controller

This block brings one switchable power domain up and down when software asks it to. Software sees two 32-bit words on a small register port. The control word, at byte offset 0, holds a single collapse request bit. The status word, at byte offset 4, reports whether the domain is on, whether the last power-up or power-down finished, and whether a transition waited too long.

A sequencer turns each request into an ordered set of steps on three outputs: the power switch enable, the isolation clamp and the domain reset. Between steps it waits for the acknowledge that comes back from the switch chain. Software polls the completion flags after it changes the request. A cycle counter watches each wait for the acknowledge, and it raises a sticky flag if the wait runs past the allowed number of cycles. The default allowance is 1500 microseconds at a 100 MHz clock.

Top module: `pwr_domain_switch`

## Requirements
- R1: The control word sits at byte offset 0 and holds the collapse request in bit 0, where 1 means power down and 0 means power up. Bit 0 resets to 1 and reads back as written. The status word sits at byte offset 4. Every bit not defined here reads 0.
- R2: Out of reset the switch enable is 0, the clamp is 1, the domain reset is 1 and the status word reads 0.
- R3: Power-up goes in this order: the switch enable rises, the clamp falls on the cycle after the acknowledge is seen high, and the domain reset falls one cycle after that.
- R4: Status bit 16 (up complete) and status bit 31 (powered on) become 1 when the domain reset is released. Status bit 15 clears when a power-up begins. Bits 15 and 16 are never 1 together.
- R5: Power-down goes in this order, each step one cycle after the last: the domain reset rises, the clamp rises, the switch enable falls. The sequencer then waits for the acknowledge to go low.
- R6: Status bit 15 (down complete) becomes 1 when the acknowledge is seen low after the switch enable falls. Status bits 16 and 31 clear when a power-down begins.
- R7: Status bit 4 (timeout) becomes 1 if a wait for the acknowledge lasts TIMEOUT_CYC cycles. It stays 1 until the next transition begins. The transition still completes if the acknowledge arrives later.
- R8: A change of the request in the middle of a transition does not cut that transition short. The sequence first reaches its stable state, and then follows the current value of the request bit.
- R9: A write to the status offset or to any unmapped offset changes neither a register nor an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| sw_ack | input | 1 | Acknowledge from the switch chain |
| sw_en | output | 1 | Power switch enable |
| iso_clamp | output | 1 | Isolation clamp, 1 = clamped |
| dom_rst | output | 1 | Domain reset, 1 = held in reset |

## Verification
The bench records every change of the three control outputs and compares it, in order, against the expected step list. A design that releases the clamp before the acknowledge, or that drops the enable while the domain is still unclamped, shows up as an out-of-order event.

The acknowledge model is held stuck low to check that the timeout flag rises, stays set after a late acknowledge, and clears on the next request. A design that clears the flag too early, or that gives up on the transition, would show a wrong status word.

A request reversed mid-sequence must still produce a full up sequence followed by a full down sequence; a design that aborts the first one would emit a short event list. Writes to the status offset and to unmapped offsets must leave both words and all outputs untouched.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int CTRL_OFS     = 0;
    localparam int STAT_OFS     = 4;
    localparam int COLLAPSE_BIT = 0;
    localparam int TMO_BIT      = 4;
    localparam int DN_DONE_BIT  = 15;
    localparam int UP_DONE_BIT  = 16;
    localparam int ON_BIT       = 31;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_UP_ACK,
        ST_UP_ISO,
        ST_ON,
        ST_DN_RST,
        ST_DN_ISO,
        ST_DN_ACK
    } pds_state_e;

    typedef struct packed {
        logic sw_en;
        logic iso;
        logic rst;
    } pds_drive_t;

    typedef struct packed {
        logic on;
        logic up_done;
        logic dn_done;
        logic timeout;
    } pds_status_t;

    function automatic pds_drive_t drive_of(pds_state_e s);
        pds_drive_t d;
        case (s)
            ST_OFF:    d = '{sw_en: 1'b0, iso: 1'b1, rst: 1'b1};
            ST_UP_ACK: d = '{sw_en: 1'b1, iso: 1'b1, rst: 1'b1};
            ST_UP_ISO: d = '{sw_en: 1'b1, iso: 1'b0, rst: 1'b1};
            ST_ON:     d = '{sw_en: 1'b1, iso: 1'b0, rst: 1'b0};
            ST_DN_RST: d = '{sw_en: 1'b1, iso: 1'b0, rst: 1'b1};
            ST_DN_ISO: d = '{sw_en: 1'b1, iso: 1'b1, rst: 1'b1};
            ST_DN_ACK: d = '{sw_en: 1'b0, iso: 1'b1, rst: 1'b1};
            default:   d = '{sw_en: 1'b0, iso: 1'b1, rst: 1'b1};
        endcase
        return d;
    endfunction

    function automatic logic [31:0] pack_status(pds_status_t s);
        logic [31:0] r;
        r              = '0;
        r[ON_BIT]      = s.on;
        r[UP_DONE_BIT] = s.up_done;
        r[DN_DONE_BIT] = s.dn_done;
        r[TMO_BIT]     = s.timeout;
        return r;
    endfunction

endpackage

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  pds_status_t       status,
    output logic [31:0]       rdata,
    output logic              collapse
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic ctrl_hit;
    assign ctrl_hit = wr_en && (addr == CTRL_A);

    always_ff @(posedge clk) begin
        if (rst) begin
            collapse <= 1'b1;
        end else if (ctrl_hit) begin
            collapse <= wdata[COLLAPSE_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_A) begin
            rdata[COLLAPSE_BIT] = collapse;
        end else if (addr == STAT_A) begin
            rdata = pack_status(status);
        end
    end

    AST_COLLAPSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == CTRL_A) |=> $stable(collapse)); // R9

endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
    parameter int LIMIT = 150000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0)); // R7

endmodule

// File: rtl/pds_seq.sv
module pds_seq
    import pds_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        collapse,
    input  logic        sw_ack,
    input  logic        expired,
    output pds_drive_t  drive,
    output pds_status_t status,
    output logic        waiting
);

    pds_state_e st, nxt;
    logic up_done, dn_done, tmo;
    logic start_up, start_dn;

    assign start_up = (st == ST_OFF) && !collapse;
    assign start_dn = (st == ST_ON) && collapse;

    always_comb begin
        nxt = st;
        case (st)
            ST_OFF:    if (start_up) nxt = ST_UP_ACK;
            ST_UP_ACK: if (sw_ack) nxt = ST_UP_ISO;
            ST_UP_ISO: nxt = ST_ON;
            ST_ON:     if (start_dn) nxt = ST_DN_RST;
            ST_DN_RST: nxt = ST_DN_ISO;
            ST_DN_ISO: nxt = ST_DN_ACK;
            ST_DN_ACK: if (!sw_ack) nxt = ST_OFF;
            default:   nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_OFF;
            up_done <= 1'b0;
            dn_done <= 1'b0;
            tmo     <= 1'b0;
        end else begin
            st <= nxt;
            if (start_dn) begin
                up_done <= 1'b0;
            end else if (st == ST_UP_ISO) begin
                up_done <= 1'b1;
            end
            if (start_up) begin
                dn_done <= 1'b0;
            end else if (st == ST_DN_ACK && !sw_ack) begin
                dn_done <= 1'b1;
            end
            if (start_up || start_dn) begin
                tmo <= 1'b0;
            end else if (expired) begin
                tmo <= 1'b1;
            end
        end
    end

    assign drive   = drive_of(st);
    assign waiting = (st == ST_UP_ACK) || (st == ST_DN_ACK);
    assign status  = '{on: (st == ST_ON), up_done: up_done,
                       dn_done: dn_done, timeout: tmo};

    AST_UNCLAMP_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(drive.iso) |-> sw_ack); // R3
    AST_RST_AFTER_UNCLAMP: assert property (@(posedge clk) disable iff (rst)
        $fell(drive.rst) |-> (!drive.iso && $past(!drive.iso))); // R3
    AST_EN_OFF_SAFE: assert property (@(posedge clk) disable iff (rst)
        $fell(drive.sw_en) |-> (drive.iso && drive.rst)); // R5
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(status.up_done && status.dn_done)); // R4
    AST_TMO_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(status.timeout) |-> $past(waiting)); // R7

endmodule

// File: rtl/pwr_domain_switch.sv
module pwr_domain_switch
    import pds_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int TIMEOUT_CYC = 150000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              sw_ack,
    output logic              sw_en,
    output logic              iso_clamp,
    output logic              dom_rst
);

    logic        collapse;
    logic        waiting;
    logic        expired;
    pds_drive_t  drive;
    pds_status_t status;

    pds_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .status   (status),
        .rdata    (reg_rdata),
        .collapse (collapse)
    );

    pds_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (waiting),
        .expired (expired)
    );

    pds_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .collapse (collapse),
        .sw_ack   (sw_ack),
        .expired  (expired),
        .drive    (drive),
        .status   (status),
        .waiting  (waiting)
    );

    assign sw_en     = drive.sw_en;
    assign iso_clamp = drive.iso;
    assign dom_rst   = drive.rst;

endmodule

// File: tb/sim_pwr_domain_switch.sv
module sim_pwr_domain_switch;

    localparam int CLK_PERIOD = 10;
    localparam int TO_CYC     = 40;
    localparam int ACK_DLY    = 5;
    localparam logic [31:0] S_ON  = 32'h8000_0000;
    localparam logic [31:0] S_UP  = 32'h0001_0000;
    localparam logic [31:0] S_DN  = 32'h0000_8000;
    localparam logic [31:0] S_TMO = 32'h0000_0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sw_ack = 1'b0;
    logic        sw_en, iso_clamp, dom_rst;
    logic        ack_block = 1'b0;
    logic [ACK_DLY-1:0] pipe = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [2:0] exp_q[$];
    logic [2:0] prev = 3'b011;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_domain_switch #(.ADDR_W(4), .TIMEOUT_CYC(TO_CYC)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sw_ack(sw_ack),
        .sw_en(sw_en), .iso_clamp(iso_clamp), .dom_rst(dom_rst)
    );

    // delayed acknowledge model of the switch chain
    always @(posedge clk) begin
        pipe <= {pipe[ACK_DLY-2:0], sw_en};
        if (!ack_block) sw_ack <= pipe[ACK_DLY-1];
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every change of {sw_en, iso_clamp, dom_rst} is popped and compared
    always @(negedge clk) begin
        if (!rst) begin
            logic [2:0] cur;
            cur = {sw_en, iso_clamp, dom_rst};
            if (cur !== prev) begin
                if (exp_q.size() == 0) begin
                    check("R3/R5 unexpected step", {29'd0, cur}, {29'd0, prev});
                end else begin
                    check("R3/R5 step order", {29'd0, cur}, {29'd0, exp_q.pop_front()});
                end
                prev = cur;
            end
        end
    end

    task automatic push_up();
        exp_q.push_back(3'b111);
        exp_q.push_back(3'b101);
        exp_q.push_back(3'b100);
    endtask

    task automatic push_down();
        exp_q.push_back(3'b101);
        exp_q.push_back(3'b111);
        exp_q.push_back(3'b011);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_bit(int b, int maxc);
        logic [31:0] v;
        for (int i = 0; i < maxc; i++) begin
            rd(4'd4, v);
            if (v[b]) break;
        end
    endtask

    task automatic outs(string req, logic [2:0] e);
        check(req, {29'd0, sw_en, iso_clamp, dom_rst}, {29'd0, e});
    endtask

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        outs("R2 reset outputs", 3'b011);
        rd(4'd4, v); check("R2 reset status", v, 32'h0);
        rd(4'd0, v); check("R1 ctrl reset value", v, 32'h1);

        // power up
        push_up();
        wr(4'd0, 32'h0);
        rd(4'd0, v); check("R1 ctrl readback", v, 32'h0);
        wait_bit(16, 100);
        rd(4'd4, v); check("R4 up status", v, S_ON | S_UP);
        outs("R3 on outputs", 3'b100);

        // ignored writes
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd8, 32'h1);
        outs("R9 outputs unchanged", 3'b100);
        rd(4'd4, v); check("R9 status unchanged", v, S_ON | S_UP);
        rd(4'd0, v); check("R9 ctrl unchanged", v, 32'h0);
        rd(4'd8, v); check("R1 unmapped reads zero", v, 32'h0);

        // power down
        push_down();
        wr(4'd0, 32'h1);
        wait_bit(15, 100);
        rd(4'd4, v); check("R6 down status", v, S_DN);
        outs("R5 off outputs", 3'b011);

        // stuck acknowledge -> timeout
        ack_block = 1'b1;
        push_up();
        wr(4'd0, 32'h0);
        repeat (TO_CYC + 20) @(negedge clk);
        rd(4'd4, v); check("R7 timeout raised", v, S_TMO);
        outs("R7 still waiting", 3'b111);
        ack_block = 1'b0;
        wait_bit(16, 100);
        rd(4'd4, v); check("R7 sticky after late ack", v, S_ON | S_UP | S_TMO);
        push_down();
        wr(4'd0, 32'h1);
        wait_bit(15, 100);
        rd(4'd4, v); check("R7 cleared by new transition", v, S_DN);

        // request reversed mid-transition
        push_up();
        push_down();
        wr(4'd0, 32'h0);
        repeat (2) @(negedge clk);
        wr(4'd0, 32'h1);
        repeat (100) @(negedge clk);
        rd(4'd4, v); check("R8 final status", v, S_DN);
        outs("R8 final outputs", 3'b011);
        check("R8 all steps seen", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule